// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit with Selective Flag Update

This block is the data-path core of a small 8-bit processor. It takes the working-register value and a second operand, and returns an 8-bit result for one of thirteen operations. The second operand is either a value read from the register file or an immediate literal taken from the instruction word. The operations are addition, subtraction, three bitwise logic functions, pass-through, clear, complement, increment, decrement, rotate left or right through the carry, and nibble swap. Alongside the result it produces new carry, digit-carry and zero flags. It also produces one update-enable per flag, so that the surrounding status register only changes the flags that the operation owns.

The unit is purely combinational, and every output settles from the current inputs. Subtraction takes the working register away from the second operand. Its carry and digit-carry are active-high "no borrow" indications, for the whole byte and for the low nibble. The caller applies the result and the flag enables to its own storage.

Top module: `alu8_core`

## Requirements
- R1: With op_sel = 0 (add), result is (B + W) mod 256, where B is the selected second operand and W is the working register. c_out is the carry out of bit 7 and dc_out is the carry out of bit 3.
- R2: With op_sel = 1 (subtract), result is (B - W) mod 256. c_out is 1 exactly when B >= W. dc_out is 1 exactly when B[3:0] >= W[3:0].
- R3: When use_lit is 1, the second operand B is lit_in. Otherwise B is file_in, and the input that is not selected has no effect on any output.
- R4: op_sel = 2, 3 and 4 give W AND B, W OR B and W XOR B respectively.
- R5: Whenever upd_z is 1, z_out is 1 exactly when result is 0x00.
- R6: Flag masks. Add and subtract assert upd_c, upd_dc and upd_z. The two rotates assert only upd_c. Logic, pass, clear, complement, increment and decrement assert only upd_z. Swap asserts none. The unused codes 13 to 15 assert none and return B.
- R7: op_sel = 10 rotates left through carry, giving {B[6:0], c_in} with c_out = B[7]. op_sel = 11 rotates right through carry, giving {c_in, B[7:1]} with c_out = B[0].
- R8: op_sel = 5 passes B, 6 gives 0x00, 7 gives ~B, 8 gives B + 1 mod 256 (0xFF wraps to 0x00), and 9 gives B - 1 mod 256 (0x00 wraps to 0xFF).
- R9: op_sel = 12 returns B with its two nibbles exchanged, {B[3:0], B[7:4]}.
- R10: A flag output whose update-enable is 0 is driven to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w_in | input | 8 | Working-register operand |
| file_in | input | 8 | Register-file operand |
| lit_in | input | 8 | Immediate literal operand |
| use_lit | input | 1 | Selects the literal (1) or the file value (0) as operand B |
| op_sel | input | 4 | Operation code, values as in the requirements |
| c_in | input | 1 | Present carry flag, used by the rotates |
| result | output | 8 | Operation result |
| c_out | output | 1 | New carry / no-borrow flag |
| dc_out | output | 1 | New digit carry / digit no-borrow flag |
| z_out | output | 1 | New zero flag |
| upd_c | output | 1 | Carry flag update enable |
| upd_dc | output | 1 | Digit-carry flag update enable |
| upd_z | output | 1 | Zero flag update enable |

## Verification
The bench targets the subtraction edges: equal operands, B one below W, and low nibbles that are equal or just apart. A design that treated carry as a borrow, or that took W minus B, would show an inverted or wrong c_out and dc_out there. Add is driven at 0xFF+0x01 and 0x0F+0x01, which catches a carry taken from the wrong bit or a missing digit carry. Rotates are run with both carry-in values, because a plain shift drops the incoming carry. The bench also checks the masks of swap, rotate and the unused codes, since an extra enable would corrupt a flag the program relies on.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    parameter int DATA_W  = 8;
    parameter int DIGIT_W = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_IOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_PASS = 4'd5,
        OP_CLR  = 4'd6,
        OP_COMP = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_RLC  = 4'd10,
        OP_RRC  = 4'd11,
        OP_SWAP = 4'd12,
        OP_RSV0 = 4'd13,
        OP_RSV1 = 4'd14,
        OP_RSV2 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        FCLS_ARITH,
        FCLS_CARRY,
        FCLS_ZERO,
        FCLS_NONE
    } flag_class_e;

    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flag_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             cy_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             cy_out,
    output logic             dcy_out
);
    localparam int FULL_W = WIDTH + 1;
    localparam int LOW_W  = DIGIT + 1;

    logic [FULL_W-1:0] full_sum;
    logic [LOW_W-1:0]  low_sum;

    always_comb begin
        full_sum = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, cy_in};
        low_sum  = {1'b0, a_in[DIGIT-1:0]} + {1'b0, b_in[DIGIT-1:0]}
                 + {{DIGIT{1'b0}}, cy_in};
    end

    assign sum_out = full_sum[WIDTH-1:0];
    assign cy_out  = full_sum[WIDTH];
    assign dcy_out = low_sum[DIGIT];

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] w_val,
    input  logic [WIDTH-1:0] b_val,
    output logic [WIDTH-1:0] res
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (op)
                OP_AND:  res[i] = w_val[i] & b_val[i];
                OP_IOR:  res[i] = w_val[i] | b_val[i];
                OP_XOR:  res[i] = w_val[i] ^ b_val[i];
                OP_COMP: res[i] = ~b_val[i];
                OP_CLR:  res[i] = 1'b0;
                default: res[i] = b_val[i];
            endcase
        end
    end

endmodule

// File: rtl/alu8_rotate.sv
module alu8_rotate #(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input  logic [WIDTH-1:0] b_val,
    input  logic             cy_in,
    input  logic             go_left,
    output logic [WIDTH-1:0] rot_out,
    output logic             cy_out,
    output logic [WIDTH-1:0] swap_out
);
    localparam int HI_W = WIDTH - DIGIT;

    always_comb begin
        if (go_left) begin
            rot_out = {b_val[WIDTH-2:0], cy_in};
            cy_out  = b_val[WIDTH-1];
        end else begin
            rot_out = {cy_in, b_val[WIDTH-1:1]};
            cy_out  = b_val[0];
        end
    end

    assign swap_out = {b_val[DIGIT-1:0], b_val[WIDTH-1:WIDTH-HI_W]};

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] res,
    input  logic             arith_cy,
    input  logic             arith_dcy,
    input  logic             rot_cy,
    output flag_t            value,
    output flag_t            mask
);
    flag_class_e fcls;

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:   fcls = FCLS_ARITH;
            OP_RLC, OP_RRC:   fcls = FCLS_CARRY;
            OP_AND, OP_IOR, OP_XOR, OP_PASS,
            OP_CLR, OP_COMP, OP_INC, OP_DEC:
                              fcls = FCLS_ZERO;
            default:          fcls = FCLS_NONE;
        endcase
    end

    always_comb begin
        mask  = '0;
        value = '0;
        unique case (fcls)
            FCLS_ARITH: begin
                mask     = '{c: 1'b1, dc: 1'b1, z: 1'b1};
                value.c  = arith_cy;
                value.dc = arith_dcy;
                value.z  = (res == '0);
            end
            FCLS_CARRY: begin
                mask.c  = 1'b1;
                value.c = rot_cy;
            end
            FCLS_ZERO: begin
                mask.z  = 1'b1;
                value.z = (res == '0);
            end
            default: begin
                mask  = '0;
                value = '0;
            end
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int DIGIT = DIGIT_W
) (
    input  logic [WIDTH-1:0] w_in,
    input  logic [WIDTH-1:0] file_in,
    input  logic [WIDTH-1:0] lit_in,
    input  logic             use_lit,
    input  logic [3:0]       op_sel,
    input  logic             c_in,
    output logic [WIDTH-1:0] result,
    output logic             c_out,
    output logic             dc_out,
    output logic             z_out,
    output logic             upd_c,
    output logic             upd_dc,
    output logic             upd_z
);
    alu_op_e          op;
    logic [WIDTH-1:0] b_opnd;
    logic [WIDTH-1:0] add_a, add_b;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cy, add_dcy;
    logic [WIDTH-1:0] bit_res;
    logic [WIDTH-1:0] rot_res, swap_res;
    logic             rot_cy;
    flag_t            fval, fmask;

    assign op     = alu_op_e'(op_sel);
    assign b_opnd = use_lit ? lit_in : file_in;

    // Adder operand steering: subtract is B + ~W + 1, inc adds 1, dec adds all-ones.
    always_comb begin
        add_a = b_opnd;
        unique case (op)
            OP_SUB:  begin add_b = ~w_in;        add_cin = 1'b1; end
            OP_INC:  begin add_b = '0;           add_cin = 1'b1; end
            OP_DEC:  begin add_b = '1;           add_cin = 1'b0; end
            default: begin add_b = w_in;         add_cin = 1'b0; end
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_addsub (
        .a_in    (add_a),
        .b_in    (add_b),
        .cy_in   (add_cin),
        .sum_out (add_sum),
        .cy_out  (add_cy),
        .dcy_out (add_dcy)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .op    (op),
        .w_val (w_in),
        .b_val (b_opnd),
        .res   (bit_res)
    );

    alu8_rotate #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_rotate (
        .b_val    (b_opnd),
        .cy_in    (c_in),
        .go_left  (op == OP_RLC),
        .rot_out  (rot_res),
        .cy_out   (rot_cy),
        .swap_out (swap_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC: result = add_sum;
            OP_RLC, OP_RRC:                 result = rot_res;
            OP_SWAP:                        result = swap_res;
            default:                        result = bit_res;
        endcase
    end

    alu8_flags #(.WIDTH(WIDTH)) u_flags (
        .op        (op),
        .res       (result),
        .arith_cy  (add_cy),
        .arith_dcy (add_dcy),
        .rot_cy    (rot_cy),
        .value     (fval),
        .mask      (fmask)
    );

    assign c_out  = fval.c;
    assign dc_out = fval.dc;
    assign z_out  = fval.z;
    assign upd_c  = fmask.c;
    assign upd_dc = fmask.dc;
    assign upd_z  = fmask.z;

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int WIDTH = 8,
    parameter int DIGIT = 4
) (
    input logic [WIDTH-1:0] w_in,
    input logic [WIDTH-1:0] file_in,
    input logic [WIDTH-1:0] lit_in,
    input logic             use_lit,
    input logic [3:0]       op_sel,
    input logic             c_in,
    input logic [WIDTH-1:0] result,
    input logic             c_out,
    input logic             dc_out,
    input logic             z_out,
    input logic             upd_c,
    input logic             upd_dc,
    input logic             upd_z
);
    logic [WIDTH-1:0] b_seen;
    logic [WIDTH:0]   wide_sum;

    always_comb begin
        b_seen   = use_lit ? lit_in : file_in;
        wide_sum = {1'b0, b_seen} + {1'b0, w_in};

        if (upd_z) begin
            assert_zero_R5: assert (z_out == (result == '0))
                else $error("zero flag disagrees with result");
        end
        if (op_sel == 4'd0) begin
            assert_add_R1: assert ({c_out, result} == wide_sum)
                else $error("add result or carry wrong");
        end
        if (op_sel == 4'd1) begin
            assert_sub_nb_R2: assert (c_out == (b_seen >= w_in))
                else $error("subtract no-borrow wrong");
        end
        if (op_sel == 4'd10 || op_sel == 4'd11) begin
            assert_rot_mask_R6: assert (upd_c && !upd_dc && !upd_z)
                else $error("rotate flag mask wrong");
        end
        if (op_sel == 4'd12) begin
            assert_swap_R9: assert (!upd_c && !upd_dc && !upd_z &&
                                    result == {b_seen[DIGIT-1:0], b_seen[WIDTH-1:DIGIT]})
                else $error("swap result or mask wrong");
        end
        assert_idle_R10: assert ((upd_c || !c_out) && (upd_dc || !dc_out) && (upd_z || !z_out))
            else $error("flag driven without update enable");
    end

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH), .DIGIT(DIGIT)) u_chk (
    .w_in    (w_in),
    .file_in (file_in),
    .lit_in  (lit_in),
    .use_lit (use_lit),
    .op_sel  (op_sel),
    .c_in    (c_in),
    .result  (result),
    .c_out   (c_out),
    .dc_out  (dc_out),
    .z_out   (z_out),
    .upd_c   (upd_c),
    .upd_dc  (upd_dc),
    .upd_z   (upd_z)
);

// File: tb/alu8_core_bench.sv
`timescale 1ns/1ps
module alu8_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] w_in = 8'h00, file_in = 8'h00, lit_in = 8'h00;
    logic       use_lit = 1'b0, c_in = 1'b0;
    logic [3:0] op_sel = 4'd0;
    logic [7:0] result;
    logic       c_out, dc_out, z_out, upd_c, upd_dc, upd_z;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    alu8_core u_alu8_core (
        .w_in(w_in), .file_in(file_in), .lit_in(lit_in), .use_lit(use_lit),
        .op_sel(op_sel), .c_in(c_in), .result(result), .c_out(c_out),
        .dc_out(dc_out), .z_out(z_out), .upd_c(upd_c), .upd_dc(upd_dc), .upd_z(upd_z)
    );

    // Behavioural model on integers: {result, c, dc, z, uc, udc, uz}
    function automatic logic [13:0] model(int op, int w, int b, int c);
        int r = 0;
        int cc = 0, dd = 0, uc = 0, ud = 0, uz = 0, zz;
        case (op)
            0:  begin r = b + w; cc = (r > 255); dd = ((b % 16) + (w % 16)) > 15;
                      uc = 1; ud = 1; uz = 1; end
            1:  begin r = b - w; cc = (b >= w); dd = ((b % 16) >= (w % 16));
                      uc = 1; ud = 1; uz = 1; end
            2:  begin r = b & w; uz = 1; end
            3:  begin r = b | w; uz = 1; end
            4:  begin r = b ^ w; uz = 1; end
            5:  begin r = b;       uz = 1; end
            6:  begin r = 0;       uz = 1; end
            7:  begin r = 255 - b; uz = 1; end
            8:  begin r = b + 1;   uz = 1; end
            9:  begin r = b - 1;   uz = 1; end
            10: begin r = b * 2 + c;   cc = (b >= 128); uc = 1; end
            11: begin r = b / 2 + c * 128; cc = b % 2; uc = 1; end
            12: begin r = (b % 16) * 16 + b / 16; end
            default: r = b;
        endcase
        r  = r & 255;
        zz = uz ? (r == 0) : 0;
        if (uc == 0) cc = 0;
        if (ud == 0) dd = 0;
        return {r[7:0], cc[0], dd[0], zz[0], uc[0], ud[0], uz[0]};
    endfunction

    function automatic string op_req(int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R4";
            5, 6, 7, 8, 9: return "R8";
            10, 11: return "R7";
            12: return "R9";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input int op, input int w, input int f, input int l,
                         input bit lit, input bit c);
        @(posedge clk);
        #2;
        op_sel = op[3:0]; w_in = w[7:0]; file_in = f[7:0]; lit_in = l[7:0];
        use_lit = lit; c_in = c;
    endtask

    task automatic check(input string req);
        logic [13:0] exp_v, act_v;
        @(negedge clk);
        exp_v = model(int'(op_sel), int'(w_in), use_lit ? int'(lit_in) : int'(file_in), int'(c_in));
        act_v = {result, c_out, dc_out, z_out, upd_c, upd_dc, upd_z};
        n_tests++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s op=%0d actual=%h expected=%h", req, op_sel, act_v, exp_v);
        end
    endtask

    task automatic run(input string req, input int op, input int w, input int f,
                       input int l, input bit lit, input bit c);
        apply(op, w, f, l, lit, c);
        check(req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-time state: zero inputs, add -> 0 with Z set (R5)
        check("R5");

        // R1 add corners
        run("R1", 0, 8'h01, 8'hFF, 0, 0, 0);
        run("R1", 0, 8'h01, 8'h0F, 0, 0, 0);
        run("R1", 0, 8'h80, 8'h7F, 0, 0, 1);
        // R2 subtract corners
        run("R2", 1, 8'h42, 8'h42, 0, 0, 0);
        run("R2", 1, 8'h43, 8'h42, 0, 0, 0);
        run("R2", 1, 8'h18, 8'h27, 0, 0, 0);
        run("R2", 1, 8'h00, 8'h00, 0, 0, 1);
        // R3 operand select: unselected input must not matter
        run("R3", 0, 8'h10, 8'hEE, 8'h05, 1, 0);
        run("R3", 0, 8'h10, 8'h05, 8'hEE, 0, 0);
        run("R3", 5, 8'h00, 8'h3C, 8'hA5, 1, 0);
        // R7 rotates with both carries
        run("R7", 10, 0, 8'h81, 0, 0, 0);
        run("R7", 10, 0, 8'h40, 0, 0, 1);
        run("R7", 11, 0, 8'h01, 0, 0, 0);
        run("R7", 11, 0, 8'h00, 0, 0, 1);
        // R8 wraps
        run("R8", 8, 0, 8'hFF, 0, 0, 0);
        run("R8", 9, 0, 8'h00, 0, 0, 0);
        run("R8", 6, 8'hFF, 8'hFF, 0, 0, 1);
        // R9 swap, R6 reserved codes, R10 idle flags
        run("R9", 12, 8'hFF, 8'h00, 0, 0, 1);
        run("R6", 13, 8'h00, 8'h00, 0, 0, 1);
        run("R10", 15, 8'hFF, 8'h01, 0, 0, 1);

        // sweep every code over corner and random operands, compared each clock
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 40; k++) begin
                int w, f;
                w = (k < 4) ? (k * 85) : int'($urandom_range(0, 255));
                f = (k < 8) ? ((k % 4) * 85) : int'($urandom_range(0, 255));
                run(op_req(op), op, w, f, int'($urandom_range(0, 255)),
                    k[0], k[1]);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule